// File: doc/BRIEF.md
# DRAM normalized-to-system address translator

This block turns a channel-local normalized DRAM address into a system physical address. It takes its inputs from one range's configuration words:
- a high-address offset word;
- two base/limit word pairs;
- the fabric identifier word of the memory channel;
- a word of die and socket masks and shifts;
- a word giving the base of the legacy I/O hole.

Error-handling logic uses it to find the system page that holds a faulty DRAM location.

A one-cycle `start` strobe latches the address and all configuration words. The translation then runs through four internal steps:
1. Remove the high offset and select a base/limit pair.
2. Decode the channel, die and socket interleave, insert the interleave ID and add the base.
3. Step over the legacy hole.
4. Apply the channel hash correction and check the result against the limit.

At the end a one-cycle `done` pulse is raised. The `err` flag is valid with `done` and keeps its value until the next `done`. The translated address is written only when the whole translation succeeds.

Top module: `xlat_norm2sys`

## Requirements
- R1: After reset, `done` is 0, `err` is 0 and `sys_addr` is 0.
- R2: A `start` seen while idle latches every input. `done` is high for exactly one cycle, on the fourth rising edge after the edge that took `start`. A `start` while a translation is running is ignored and does not change its result.
- R3: Bit 0 of `hi_off` enables the offset. The offset is `hi_off[31:20]` placed at address bits 39:28. If the offset is enabled and the address is at or above it, the offset is subtracted and the pair `base1`/`limit1` is used. Otherwise the pair `base0`/`limit0` is used.
- R4: In the selected base word, bit 0 marks the range valid, and a clear bit 0 gives an error. Bits 31:12 of the base word, placed at address bits 47:28, are added to the address.
- R5: Base word bits 7:4 are the channel code. The codes 0, 1, 3, 5 and 7 give 0, 1, 2, 3 and 4 channel bits. Code 8 gives 1 channel bit with hashing. Any other code is an error. Base bits 10:8 select the interleave position 8+select, and a select value above 3 is an error.
- R6: Limit word bits 11:10 give the number of die bits and bit 8 gives the number of socket bits. A die count above 2 is an error. A total of channel, die and socket bits above 4 is an error.
- R7: The fabric ID is `fab_id[15:8]`.
  - The interleave ID is built in three fields:
    - Lowest field: the low channel bits of the fabric ID.
    - Above it: the fabric ID ANDed with the die mask `id_mask[15:8]` and shifted right by `id_mask[27:24]`.
    - Above that: the fabric ID ANDed with the socket mask `id_mask[23:16]` and shifted right by `id_mask[31:28]`.
  - If the total bit count is not zero, the address bits at and above the interleave position move up by that count. The ID is placed at the interleave position.
- R8: If base bit 1 is set and the address after the base is added is at or above `hole_base[31:24]` placed at bits 31:24, then 2^32 minus that hole base is added.
- R9: With hashing on, the XOR of address bits 12, 18, 21 and 30 and ID bit 0 is compared with the address bit at the interleave position. If they differ, that bit is inverted.
- R10: A final address above the limit is an error. The limit is limit bits 31:12 at address bits 47:28, ORed with ones in bits 27:0.
- R11: When there is an error, `sys_addr` keeps its previous value. `err` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| norm_addr | input | 64 | Normalized channel address |
| hi_off | input | 32 | High-address offset word |
| base0 | input | 32 | Base word of pair 0 |
| limit0 | input | 32 | Limit word of pair 0 |
| base1 | input | 32 | Base word of pair 1 |
| limit1 | input | 32 | Limit word of pair 1 |
| fab_id | input | 32 | Fabric identifier word of the channel |
| id_mask | input | 32 | Die/socket mask and shift word |
| hole_base | input | 32 | Legacy hole base word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Translation failed; valid from `done` until the next `done` |
| sys_addr | output | 64 | Last successful system address |

## Verification
Two events can fall into the same cycle window. One is a new `start`. The other is a translation that is still in flight.

The bench issues a second `start`, with entirely different operands, one cycle after the first. It then checks three things:
- the result matches the first operand set;
- the latency is unchanged;
- no extra `done` follows.

In a second case, an error outcome lands on the same edge that would write the output. Error vectors placed right after successful ones show that `sys_addr` holds the earlier value while `err` rises.

// File: rtl/xlat_norm2sys.sv
module xlat_norm2sys #(
  parameter int AW = 64,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] norm_addr,
  input  logic [RW-1:0] hi_off,
  input  logic [RW-1:0] base0,
  input  logic [RW-1:0] limit0,
  input  logic [RW-1:0] base1,
  input  logic [RW-1:0] limit1,
  input  logic [RW-1:0] fab_id,
  input  logic [RW-1:0] id_mask,
  input  logic [RW-1:0] hole_base,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] sys_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] FOUR_G = ONE << 32;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_MAP, S_HOLE, S_FIN} st_t;
  st_t st;

  logic [AW-1:0] na_r, a_r, lim_r;
  logic [RW-1:0] hi_r, b0_r, l0_r, b1_r, l1_r, fab_r, msk_r, hole_r, bw_r, lw_r;
  logic          bad_r, hole_en_r, hash_r;
  logic [3:0]    ipos_r;
  logic [7:0]    cs_r;
  logic [2:0]    sel_r;

  logic [AW-1:0] off_val;
  logic          use_hi;
  assign off_val = {{(AW-40){1'b0}}, hi_r[31:20], 28'd0};
  assign use_hi  = hi_r[0] && (na_r >= off_val);

  logic [2:0] ch_log;
  logic       hash_on, enc_bad;
  always_comb begin
    ch_log  = 3'd0;
    hash_on = 1'b0;
    enc_bad = 1'b0;
    case (bw_r[7:4])
      4'd0: ch_log = 3'd0;
      4'd1: ch_log = 3'd1;
      4'd3: ch_log = 3'd2;
      4'd5: ch_log = 3'd3;
      4'd7: ch_log = 3'd4;
      4'd8: begin ch_log = 3'd1; hash_on = 1'b1; end
      default: enc_bad = 1'b1;
    endcase
  end

  logic [1:0] dies;
  logic       sock;
  logic [2:0] sel;
  logic [3:0] nbits, sock_pos, ipos;
  logic       dec_bad;
  assign dies     = lw_r[11:10];
  assign sock     = lw_r[8];
  assign sel      = bw_r[10:8];
  assign nbits    = {1'b0, ch_log} + {2'b00, dies} + {3'b000, sock};
  assign sock_pos = {1'b0, ch_log} + {2'b00, dies};
  assign ipos     = 4'd8 + {2'b00, sel[1:0]};
  assign dec_bad  = !bw_r[0] || (sel > 3'd3) || enc_bad || (dies > 2'd2) || (nbits > 4'd4);

  logic [7:0] fid, ch_mask, ch_part, die_part, sock_part, cs_id;
  assign fid       = fab_r[15:8];
  assign ch_mask   = (8'd1 << ch_log) - 8'd1;
  assign ch_part   = fid & ch_mask;
  assign die_part  = (dies != 2'd0) ? (((fid & msk_r[15:8]) >> msk_r[27:24]) << ch_log) : 8'd0;
  assign sock_part = sock ? (((fid & msk_r[23:16]) >> msk_r[31:28]) << sock_pos) : 8'd0;
  assign cs_id     = ch_part | die_part | sock_part;

  logic [AW-1:0] low_m, ins_addr, base_addr, lim_addr;
  assign low_m     = (ONE << ipos) - ONE;
  assign ins_addr  = (nbits == 4'd0) ? a_r :
                     (((a_r & ~low_m) << nbits) | ({{(AW-8){1'b0}}, cs_id} << ipos) | (a_r & low_m));
  assign base_addr = {{(AW-48){1'b0}}, bw_r[31:12], 28'd0};
  assign lim_addr  = {{(AW-48){1'b0}}, lw_r[31:12], 28'hFFF_FFFF};

  logic [AW-1:0] hole_b;
  assign hole_b = {{(AW-32){1'b0}}, hole_r[31:24], 24'd0};

  logic          hbit, fin_bad;
  logic [AW-1:0] fin_addr;
  assign hbit     = a_r[12] ^ a_r[18] ^ a_r[21] ^ a_r[30] ^ cs_r[0];
  assign fin_addr = (hash_r && (hbit != a_r[ipos_r])) ? (a_r ^ (ONE << ipos_r)) : a_r;
  assign fin_bad  = bad_r || (fin_addr > lim_r);

  logic unused_bits;
  assign unused_bits = ^{hi_r[19:1], bw_r[11], bw_r[3:2], lw_r[9], lw_r[7:0],
                         fab_r[31:16], fab_r[7:0], msk_r[7:0], hole_r[23:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      sys_addr  <= '0;
      na_r      <= '0;
      a_r       <= '0;
      lim_r     <= '0;
      hi_r      <= '0;
      b0_r      <= '0;
      l0_r      <= '0;
      b1_r      <= '0;
      l1_r      <= '0;
      fab_r     <= '0;
      msk_r     <= '0;
      hole_r    <= '0;
      bw_r      <= '0;
      lw_r      <= '0;
      bad_r     <= 1'b0;
      hole_en_r <= 1'b0;
      hash_r    <= 1'b0;
      ipos_r    <= 4'd8;
      cs_r      <= '0;
      sel_r     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          na_r   <= norm_addr;
          hi_r   <= hi_off;
          b0_r   <= base0;
          l0_r   <= limit0;
          b1_r   <= base1;
          l1_r   <= limit1;
          fab_r  <= fab_id;
          msk_r  <= id_mask;
          hole_r <= hole_base;
          st     <= S_SEL;
        end
        S_SEL: begin
          a_r  <= use_hi ? (na_r - off_val) : na_r;
          bw_r <= use_hi ? b1_r : b0_r;
          lw_r <= use_hi ? l1_r : l0_r;
          st   <= S_MAP;
        end
        S_MAP: begin
          a_r       <= ins_addr + base_addr;
          bad_r     <= dec_bad;
          hole_en_r <= bw_r[1];
          hash_r    <= hash_on;
          ipos_r    <= ipos;
          cs_r      <= cs_id;
          sel_r     <= sel;
          lim_r     <= lim_addr;
          st        <= S_HOLE;
        end
        S_HOLE: begin
          if (hole_en_r && (a_r >= hole_b))
            a_r <= a_r + (FOUR_G - hole_b);
          st <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= fin_bad;
          if (!fin_bad) sys_addr <= fin_addr;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_addr) |-> (done && !err));

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err));

  // R10
  under_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (sys_addr <= lim_r));

  // R5
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (sel_r > 3'd3)) |-> err);

endmodule

// File: tb/xlat_norm2sys_tb_top.sv
module xlat_norm2sys_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] norm_addr = '0;
  logic [31:0] hi_off = '0, base0 = '0, limit0 = '0, base1 = '0, limit1 = '0;
  logic [31:0] fab_id = '0, id_mask = '0, hole_base = '0;
  logic        done, err;
  logic [63:0] sys_addr;

  always #10 clk = ~clk;

  xlat_norm2sys dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .norm_addr(norm_addr),
    .hi_off(hi_off), .base0(base0), .limit0(limit0), .base1(base1), .limit1(limit1),
    .fab_id(fab_id), .id_mask(id_mask), .hole_base(hole_base),
    .done(done), .err(err), .sys_addr(sys_addr)
  );

  typedef struct packed {
    logic [63:0] na;
    logic [31:0] hi, b0, l0, b1, l1, fab, msk, hole;
    logic        e;
    logic [63:0] x;
    logic [23:0] rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TAB [NV] = '{
    '{64'h1234, 32'h0, 32'h1001, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b0, 64'h10001234, "R4 "},
    '{64'h10000040, 32'h00100001, 32'h0, 32'hFFFFF000, 32'h2001, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b0, 64'h20000040, "R3 "},
    '{64'h500, 32'h00100001, 32'h1001, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b0, 64'h10000500, "R3 "},
    '{64'h1FF, 32'h0, 32'h11, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h300, 32'h0, 32'h0, 1'b0, 64'h3FF, "R7 "},
    '{64'hDEF, 32'h0, 32'h231, 32'hFFFFF500, 32'h0, 32'hFFFFF000, 32'hB600, 32'h74801000, 32'h0, 1'b0, 64'hF9EF, "R7 "},
    '{64'hC0001000, 32'h0, 32'h3, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'hC0000000, 1'b0, 64'h1_00001000, "R8 "},
    '{64'hBFFFFFF0, 32'h0, 32'h3, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'hC0000000, 1'b0, 64'hBFFFFFF0, "R8 "},
    '{64'h800, 32'h0, 32'h81, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b0, 64'h1100, "R9 "},
    '{64'h800, 32'h0, 32'h81, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h100, 32'h0, 32'h0, 1'b0, 64'h1000, "R9 "},
    '{64'h0, 32'h0, 32'h81, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h100, 32'h0, 32'h0, 1'b0, 64'h100, "R9 "},
    '{64'h40, 32'h0, 32'h21, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h100, "R5 "},
    '{64'h40, 32'h0, 32'h401, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h100, "R5 "},
    '{64'h40, 32'h0, 32'h1, 32'hFFFFFC00, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h100, "R6 "},
    '{64'h40, 32'h0, 32'h71, 32'hFFFFF100, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h100, "R6 "},
    '{64'h0FFFFFFF, 32'h0, 32'h1, 32'h0, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b0, 64'h0FFFFFFF, "R10"},
    '{64'h10000000, 32'h0, 32'h1, 32'h0, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h0FFFFFFF, "R10"},
    '{64'h10, 32'h0, 32'h0, 32'hFFFFF000, 32'h0, 32'hFFFFF000, 32'h0, 32'h0, 32'h0, 1'b1, 64'h0FFFFFFF, "R4 "}
  };

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    norm_addr = v.na; hi_off = v.hi; base0 = v.b0; limit0 = v.l0;
    base1 = v.b1; limit1 = v.l1; fab_id = v.fab; id_mask = v.msk; hole_base = v.hole;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int extra;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(done == 1'b0, "R1 done", {63'd0, done}, 64'd0);
    chk(err == 1'b0, "R1 err", {63'd0, err}, 64'd0);
    chk(sys_addr == 64'd0, "R1 sys_addr", sys_addr, 64'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TAB[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      chk(lat == 5, "R2 latency", 64'(lat), 64'd5);
      chk(err == TAB[i].e, {string'(TAB[i].rq), " err"}, {63'd0, err}, {63'd0, TAB[i].e});
      chk(sys_addr == TAB[i].x, {string'(TAB[i].rq), " addr"}, sys_addr, TAB[i].x);
      @(negedge clk);
      chk(done == 1'b0, "R2 pulse width", {63'd0, done}, 64'd0);
      // R11: err and address held while idle
      chk(err == TAB[i].e && sys_addr == TAB[i].x, "R11 hold", sys_addr, TAB[i].x);
    end

    // R2: second start while busy is ignored
    @(negedge clk);
    drive(TAB[0]);
    start = 1'b1;
    @(negedge clk);
    drive(TAB[3]);
    @(negedge clk);
    start = 1'b0;
    drive(TAB[10]);
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R2 busy latency", 64'(lat), 64'd5);
    chk(sys_addr == 64'h10001234 && !err, "R2 busy result", sys_addr, 64'h10001234);
    extra = 0;
    repeat (10) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R2 no extra done", 64'(extra), 64'd0);

    // R11: error right after success keeps the address, flag set
    @(negedge clk);
    drive(TAB[16]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(err == 1'b1, "R11 err set", {63'd0, err}, 64'd1);
    chk(sys_addr == 64'h10001234, "R11 addr kept", sys_addr, 64'h10001234);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    drive(TAB[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0 && sys_addr == 64'd0, "R1 reset mid-run", sys_addr, 64'd0);
    rst_n = 1'b1;
    extra = 0;
    repeat (8) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R1 no done after reset", 64'(extra), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule